// File: doc/BRIEF.md
# CAN Identifier Acceptance Filter

This block decides, for every identifier that a group of CAN controllers receives, whether the frame is kept. Software stores identifier tables in a 512-word lookup RAM and marks the table limits with six boundary registers. A two-bit mode register selects one of three behaviours. In the halted-reject state every frame is dropped. In the halted-accept state every frame is kept. In the running state a hardware search walks the relevant region of the RAM and reports the first entry that matches.

Boundary registers b0..b5 split the RAM into five tables. Table t covers words b_t up to, but not including, b_(t+1). Tables 0 to 2 hold standard entries, two per word. Tables 3 and 4 hold extended entries, one per word. A standard request therefore searches words [b0, b3), and an extended request searches words [b3, b5).

A single CPU port reaches both the RAM and the configuration registers. The rights of that port depend on the mode. While a search owns the RAM, CPU RAM accesses are held off with a wait signal, so a search never sees a half-updated entry.

Top module: `can_id_filter`

## Requirements
- R1: With mode bit 1 (bypass) set, whatever the value of mode bit 0, every request is answered with `res_done` high, `res_accept` high and `res_index` 0. The answer comes one clock after the request is taken.
- R2: With mode bit 0 (off) at 1 and bypass at 0, every request is answered one clock after it is taken, with `res_done` high and `res_accept` low.
- R3: In running mode (mode value 0), the search returns the first matching entry in address order. A standard entry is the 16-bit value {ctrl[15:14], disable[13], reserved[12:11], id[10:0]} and matches `req_ctrl` and the low 11 bits of `req_id`. The low half of word w is entry 2w and the high half is entry 2w+1, and the low half is examined first. An extended entry is the 32-bit value {ctrl[31:30], disable[29], id[28:0]}, and its index is its word address.
- R4: In running mode, a request whose region holds no matching entry, or whose region is empty (start >= end), is answered with `res_done` high and `res_accept` low.
- R5: An entry whose disable bit is 1 never matches.
- R6: In the off and bypass modes, the CPU can read and write lookup RAM words and the boundary registers. Config address 0 is the mode register (bit 0 off, bit 1 bypass), and config addresses 1 to 6 hold b0 to b5.
- R7: In running mode, writes to the boundary registers are ignored. The mode register and the boundary registers can be read in every mode.
- R8: In running mode, a CPU RAM write changes only the disable bits. These are bits 13 and 29 of a word below b3, and bit 29 of any other word. All other bits keep their old values.
- R9: A CPU RAM access whose `cpu_size` is not 2 (word) is acknowledged with `cpu_err` high and changes nothing.
- R10: A CPU RAM access made while a search is in progress sees `cpu_wait` high and completes only after that search has finished.
- R11: If the mode leaves running while a search is in progress, the search is abandoned and no `res_done` is produced for it.
- R12: After reset the mode register reads 1 (off), all boundary registers read 0, and `res_done` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | CPU access request, held until `cpu_ack` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_sel_ram | input | 1 | 1 = lookup RAM, 0 = configuration registers |
| cpu_addr | input | 9 | RAM word address, or config register number |
| cpu_size | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Read data, valid with `cpu_ack` |
| cpu_ack | output | 1 | One-cycle completion pulse |
| cpu_err | output | 1 | Access refused, valid with `cpu_ack` |
| cpu_wait | output | 1 | RAM access held off by a running search |
| req_valid | input | 1 | Identifier lookup request |
| req_ext | input | 1 | 1 = extended identifier, 0 = standard |
| req_ctrl | input | 2 | Number of the receiving controller |
| req_id | input | 29 | Identifier (standard uses bits 10:0) |
| req_ready | output | 1 | Lookup request taken when high together with `req_valid` |
| res_done | output | 1 | One-cycle result pulse |
| res_accept | output | 1 | Frame accepted, valid with `res_done` |
| res_index | output | 10 | Index of the matching entry |

## Verification
The hardest situations to reach from the ports are a CPU RAM access that lands in the middle of a search, and a mode change that cuts a search short. To reach them, the bench builds a 64-word extended table in which nothing matches, so a lookup runs for about 65 clocks. It then forks a second thread that issues a RAM write, or a write to the mode register, a few clocks after the lookup is taken. Seeded random layouts and random entries drawn from a small identifier pool produce frequent hits, misses and disabled entries. A bench model of the table checks each of these results.

// File: rtl/canf_pkg.sv
`timescale 1ns/1ps
package canf_pkg;
  // entry field positions
  localparam int CTRL_W      = 2;
  localparam int STD_ID_W    = 11;
  localparam int EXT_ID_W    = 29;
  localparam int STD_DIS_BIT = 13;
  localparam int EXT_DIS_BIT = 29;
  localparam int WORD_W      = 32;
  localparam logic [1:0] SZ_WORD = 2'd2;
  localparam logic [WORD_W-1:0] DIS_MASK_STD = 32'h2000_2000;
  localparam logic [WORD_W-1:0] DIS_MASK_EXT = 32'h2000_0000;

  typedef enum logic [1:0] {MD_RUN, MD_OFF, MD_BYP} fmode_e;

  function automatic fmode_e mode_of(input logic off_b, input logic byp_b);
    if (byp_b) return MD_BYP;
    if (off_b) return MD_OFF;
    return MD_RUN;
  endfunction
endpackage

// File: rtl/canf_lut_ram.sv
`timescale 1ns/1ps
module canf_lut_ram #(
  parameter int AW = 9,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // single port, read-first, registered output
  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[addr] <= wdata;
      rdata <= mem[addr];
    end
  end
endmodule

// File: rtl/canf_cfg_port.sv
`timescale 1ns/1ps
module canf_cfg_port
  import canf_pkg::*;
#(
  parameter int AW   = 9,
  parameter int NTAB = 5,
  parameter int NSTD = 3,
  localparam int NB  = NTAB + 1,
  localparam int BW  = AW + 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cpu_req,
  input  logic                   cpu_we,
  input  logic                   cpu_sel_ram,
  input  logic [AW-1:0]          cpu_addr,
  input  logic [1:0]             cpu_size,
  input  logic [WORD_W-1:0]      cpu_wdata,
  output logic [WORD_W-1:0]      cpu_rdata,
  output logic                   cpu_ack,
  output logic                   cpu_err,
  output logic                   cpu_wait,
  input  logic                   hold,
  output logic                   busy,
  output logic                   ram_en,
  output logic                   ram_we,
  output logic [AW-1:0]          ram_addr,
  output logic [WORD_W-1:0]      ram_wdata,
  input  logic [WORD_W-1:0]      ram_rdata,
  output fmode_e                 mode,
  output logic [NB-1:0][BW-1:0]  bnd
);
  typedef enum logic [1:0] {C_IDLE, C_RD, C_MRG} cst_e;

  cst_e                 st;
  logic                 off_q, byp_q;
  logic [NB-1:0][BW-1:0] bnd_q;
  logic [AW-1:0]        addr_q;
  logic [WORD_W-1:0]    wdata_q, mask_q, cfg_rd, mask_now;
  logic                 running, size_ok, go;

  assign mode     = mode_of(off_q, byp_q);
  assign bnd      = bnd_q;
  assign running  = (mode == MD_RUN);
  assign size_ok  = (cpu_size == SZ_WORD);
  assign busy     = (st != C_IDLE);
  assign go       = cpu_req && !cpu_ack && (st == C_IDLE) && !(cpu_sel_ram && hold);
  assign cpu_wait = cpu_req && cpu_sel_ram && hold && !cpu_ack;
  assign mask_now = ({1'b0, cpu_addr} < bnd_q[NSTD]) ? DIS_MASK_STD : DIS_MASK_EXT;

  always_comb begin
    cfg_rd = '0;
    if (cpu_addr == '0) cfg_rd = {30'd0, byp_q, off_q};
    for (int i = 0; i < NB; i++)
      if (cpu_addr == AW'(i + 1)) cfg_rd = WORD_W'(bnd_q[i]);
  end

  always_comb begin
    ram_en    = 1'b0;
    ram_we    = 1'b0;
    ram_addr  = cpu_addr;
    ram_wdata = cpu_wdata;
    if (st == C_MRG) begin
      ram_en    = 1'b1;
      ram_we    = 1'b1;
      ram_addr  = addr_q;
      ram_wdata = (ram_rdata & ~mask_q) | (wdata_q & mask_q);
    end else if (go && cpu_sel_ram && size_ok) begin
      ram_en = 1'b1;
      ram_we = cpu_we && !running;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= C_IDLE;
      off_q     <= 1'b1;
      byp_q     <= 1'b0;
      bnd_q     <= '0;
      cpu_ack   <= 1'b0;
      cpu_err   <= 1'b0;
      cpu_rdata <= '0;
      addr_q    <= '0;
      wdata_q   <= '0;
      mask_q    <= '0;
    end else begin
      cpu_ack <= 1'b0;
      cpu_err <= 1'b0;
      case (st)
        C_IDLE: if (go) begin
          if (cpu_sel_ram) begin
            if (!size_ok) begin
              cpu_ack <= 1'b1;
              cpu_err <= 1'b1;
            end else if (!cpu_we) begin
              st <= C_RD;
            end else if (running) begin
              st      <= C_MRG;
              addr_q  <= cpu_addr;
              wdata_q <= cpu_wdata;
              mask_q  <= mask_now;
            end else begin
              cpu_ack <= 1'b1;
            end
          end else begin
            cpu_ack <= 1'b1;
            if (!cpu_we) begin
              cpu_rdata <= cfg_rd;
            end else if (cpu_addr == '0) begin
              off_q <= cpu_wdata[0];
              byp_q <= cpu_wdata[1];
            end else if (!running) begin
              for (int i = 0; i < NB; i++)
                if (cpu_addr == AW'(i + 1)) bnd_q[i] <= cpu_wdata[BW-1:0];
            end
          end
        end
        C_RD: begin
          cpu_rdata <= ram_rdata;
          cpu_ack   <= 1'b1;
          st        <= C_IDLE;
        end
        C_MRG: begin
          cpu_ack <= 1'b1;
          st      <= C_IDLE;
        end
        default: st <= C_IDLE;
      endcase
    end
  end

  // layout registers frozen while the filter runs
  p_cfg_locked_r7: assert property (@(posedge clk) disable iff (rst)
    (mode == MD_RUN) |=> $stable(bnd_q));
  // in running mode RAM is only written through the merge step
  p_run_merge_r8: assert property (@(posedge clk) disable iff (rst)
    (ram_we && running) |-> (st == C_MRG));
  // refusal flag only travels with an acknowledge
  p_err_ack_r9: assert property (@(posedge clk) disable iff (rst)
    cpu_err |-> cpu_ack);
  // a held-off access never completes in the same cycle
  p_wait_noack_r10: assert property (@(posedge clk) disable iff (rst)
    (cpu_wait && st == C_IDLE) |=> !cpu_ack);
endmodule

// File: rtl/canf_search.sv
`timescale 1ns/1ps
module canf_search
  import canf_pkg::*;
#(
  parameter int AW   = 9,
  parameter int NTAB = 5,
  parameter int NSTD = 3,
  localparam int NB  = NTAB + 1,
  localparam int BW  = AW + 1,
  localparam int IW  = AW + 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  fmode_e                mode,
  input  logic [NB-1:0][BW-1:0] bnd,
  input  logic                  cpu_claim,
  input  logic                  req_valid,
  input  logic                  req_ext,
  input  logic [CTRL_W-1:0]     req_ctrl,
  input  logic [EXT_ID_W-1:0]   req_id,
  output logic                  req_ready,
  output logic                  busy,
  output logic                  ram_en,
  output logic [AW-1:0]         ram_addr,
  input  logic [WORD_W-1:0]     ram_rdata,
  output logic                  res_done,
  output logic                  res_accept,
  output logic [IW-1:0]         res_index
);
  typedef enum logic {S_IDLE, S_SCAN} sst_e;

  sst_e                st;
  logic [BW-1:0]       ptr_q, end_q, lo_b, hi_b;
  logic [AW-1:0]       cmp_q;
  logic                pend_q, ext_q;
  logic [CTRL_W-1:0]   ctrl_q;
  logic [EXT_ID_W-1:0] id_q;
  logic                running, hit_lo, hit_hi, hit_x, hit, last;
  logic [IW-1:0]       hit_idx;

  assign running   = (mode == MD_RUN);
  assign busy      = (st == S_SCAN);
  assign req_ready = (st == S_IDLE) && (!running || !cpu_claim);
  assign lo_b      = req_ext ? bnd[NSTD] : bnd[0];
  assign hi_b      = req_ext ? bnd[NTAB] : bnd[NSTD];
  assign ram_en    = busy && running && (ptr_q < end_q);
  assign ram_addr  = ptr_q[AW-1:0];

  // entry compare on the word read in the previous cycle
  assign hit_lo = !ext_q && !ram_rdata[STD_DIS_BIT]
               && (ram_rdata[15:14] == ctrl_q)
               && (ram_rdata[STD_ID_W-1:0] == id_q[STD_ID_W-1:0]);
  assign hit_hi = !ext_q && !ram_rdata[16+STD_DIS_BIT]
               && (ram_rdata[31:30] == ctrl_q)
               && (ram_rdata[16+STD_ID_W-1:16] == id_q[STD_ID_W-1:0]);
  assign hit_x  = ext_q && !ram_rdata[EXT_DIS_BIT]
               && (ram_rdata[31:30] == ctrl_q)
               && (ram_rdata[EXT_ID_W-1:0] == id_q);
  assign hit     = pend_q && (hit_lo || hit_hi || hit_x);
  assign last    = pend_q && ((BW'(cmp_q) + BW'(1)) == end_q);
  assign hit_idx = ext_q ? {1'b0, cmp_q} : {cmp_q, ~hit_lo};

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= S_IDLE;
      ptr_q      <= '0;
      end_q      <= '0;
      cmp_q      <= '0;
      pend_q     <= 1'b0;
      ext_q      <= 1'b0;
      ctrl_q     <= '0;
      id_q       <= '0;
      res_done   <= 1'b0;
      res_accept <= 1'b0;
      res_index  <= '0;
    end else begin
      res_done   <= 1'b0;
      res_accept <= 1'b0;
      case (st)
        S_IDLE: begin
          pend_q <= 1'b0;
          if (req_valid && req_ready) begin
            if (!running) begin
              res_done   <= 1'b1;
              res_accept <= (mode == MD_BYP);
              res_index  <= '0;
            end else if (lo_b >= hi_b) begin
              res_done  <= 1'b1;
              res_index <= '0;
            end else begin
              st     <= S_SCAN;
              ptr_q  <= lo_b;
              end_q  <= hi_b;
              ext_q  <= req_ext;
              ctrl_q <= req_ctrl;
              id_q   <= req_id;
            end
          end
        end
        S_SCAN: begin
          if (!running) begin
            st     <= S_IDLE;
            pend_q <= 1'b0;
          end else if (hit) begin
            st         <= S_IDLE;
            pend_q     <= 1'b0;
            res_done   <= 1'b1;
            res_accept <= 1'b1;
            res_index  <= hit_idx;
          end else if (last) begin
            st        <= S_IDLE;
            pend_q    <= 1'b0;
            res_done  <= 1'b1;
            res_index <= '0;
          end else begin
            pend_q <= ram_en;
            cmp_q  <= ptr_q[AW-1:0];
            if (ram_en) ptr_q <= ptr_q + BW'(1);
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_bypass_all_r1: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && mode == MD_BYP) |=> (res_done && res_accept));
  p_off_none_r2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && mode == MD_OFF) |=> (res_done && !res_accept));
  p_accept_done_r3: assert property (@(posedge clk) disable iff (rst)
    res_accept |-> res_done);
  p_abort_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    (busy && !running) |=> !res_done);
endmodule

// File: rtl/can_id_filter.sv
`timescale 1ns/1ps
module can_id_filter
  import canf_pkg::*;
#(
  parameter int AW   = 9,
  parameter int NTAB = 5,
  parameter int NSTD = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cpu_req,
  input  logic                cpu_we,
  input  logic                cpu_sel_ram,
  input  logic [AW-1:0]       cpu_addr,
  input  logic [1:0]          cpu_size,
  input  logic [31:0]         cpu_wdata,
  output logic [31:0]         cpu_rdata,
  output logic                cpu_ack,
  output logic                cpu_err,
  output logic                cpu_wait,
  input  logic                req_valid,
  input  logic                req_ext,
  input  logic [1:0]          req_ctrl,
  input  logic [28:0]         req_id,
  output logic                req_ready,
  output logic                res_done,
  output logic                res_accept,
  output logic [AW:0]         res_index
);
  localparam int NB = NTAB + 1;
  localparam int BW = AW + 1;

  fmode_e                mode;
  logic [NB-1:0][BW-1:0] bnd;
  logic                  s_busy, s_en, c_busy, c_en, c_we, cpu_claim;
  logic [AW-1:0]         s_addr, c_addr, m_addr;
  logic [31:0]           c_wdata, m_rdata;

  assign cpu_claim = (cpu_req && cpu_sel_ram) || c_busy;
  assign m_addr    = s_busy ? s_addr : c_addr;

  canf_cfg_port #(.AW(AW), .NTAB(NTAB), .NSTD(NSTD)) u_cfg (
    .clk, .rst,
    .cpu_req, .cpu_we, .cpu_sel_ram, .cpu_addr, .cpu_size, .cpu_wdata,
    .cpu_rdata, .cpu_ack, .cpu_err, .cpu_wait,
    .hold(s_busy), .busy(c_busy),
    .ram_en(c_en), .ram_we(c_we), .ram_addr(c_addr), .ram_wdata(c_wdata),
    .ram_rdata(m_rdata), .mode, .bnd
  );

  canf_search #(.AW(AW), .NTAB(NTAB), .NSTD(NSTD)) u_srch (
    .clk, .rst, .mode, .bnd, .cpu_claim,
    .req_valid, .req_ext, .req_ctrl, .req_id, .req_ready,
    .busy(s_busy), .ram_en(s_en), .ram_addr(s_addr), .ram_rdata(m_rdata),
    .res_done, .res_accept, .res_index
  );

  canf_lut_ram #(.AW(AW), .DW(32)) u_ram (
    .clk, .en(s_en || c_en), .we(c_we && !s_busy),
    .addr(m_addr), .wdata(c_wdata), .rdata(m_rdata)
  );

  // the CPU never drives the RAM port while a search owns it
  p_ram_owner_r10: assert property (@(posedge clk) disable iff (rst)
    c_en |-> !s_busy);
  p_single_owner_r10: assert property (@(posedge clk) disable iff (rst)
    !(c_en && s_en));
endmodule

// File: tb/can_id_filter_test.sv
`timescale 1ns/1ps
module can_id_filter_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_req = 1'b0, cpu_we = 1'b0, cpu_sel_ram = 1'b0;
  logic [8:0]  cpu_addr = '0;
  logic [1:0]  cpu_size = 2'd2;
  logic [31:0] cpu_wdata = '0;
  logic [31:0] cpu_rdata;
  logic        cpu_ack, cpu_err, cpu_wait;
  logic        req_valid = 1'b0, req_ext = 1'b0;
  logic [1:0]  req_ctrl = '0;
  logic [28:0] req_id = '0;
  logic        req_ready, res_done, res_accept;
  logic [9:0]  res_index;

  int checks = 0;
  int errors = 0;
  bit summary_done = 0;
  logic [31:0] mdl [64];
  int b [6];

  always #2.5 clk = ~clk;

  can_id_filter uut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cpu_op(input logic we, input logic ram, input logic [8:0] addr,
                        input logic [1:0] sz, input logic [31:0] wd,
                        output logic [31:0] rd, output logic er, output logic saw_wait);
    int t;
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_sel_ram = ram; cpu_addr = addr;
    cpu_size = sz; cpu_wdata = wd;
    saw_wait = cpu_wait; t = 0;
    do begin
      @(negedge clk);
      if (cpu_wait) saw_wait = 1'b1;
      t++;
    end while (!cpu_ack && t < 2000);
    rd = cpu_rdata; er = cpu_err;
    if (!cpu_ack) chk("cpu ack timeout", 32'd0, 32'd1);
    cpu_req = 1'b0;
  endtask

  task automatic cfg_wr(input int a, input int v);
    logic [31:0] rd; logic er, w;
    cpu_op(1'b1, 1'b0, 9'(a), 2'd2, 32'(v), rd, er, w);
  endtask

  task automatic cfg_rd(input int a, output logic [31:0] v);
    logic er, w;
    cpu_op(1'b0, 1'b0, 9'(a), 2'd2, 32'd0, v, er, w);
  endtask

  task automatic ram_wr(input int a, input logic [31:0] v);
    logic [31:0] rd; logic er, w;
    cpu_op(1'b1, 1'b1, 9'(a), 2'd2, v, rd, er, w);
  endtask

  task automatic ram_rd(input int a, output logic [31:0] v);
    logic er, w;
    cpu_op(1'b0, 1'b1, 9'(a), 2'd2, 32'd0, v, er, w);
  endtask

  task automatic lookup(input logic ext, input logic [1:0] ctrl, input logic [28:0] id,
                        output logic got, output logic acc, output logic [9:0] idx);
    int t;
    @(negedge clk);
    req_valid = 1'b1; req_ext = ext; req_ctrl = ctrl; req_id = id; t = 0;
    while (!req_ready && t < 1000) begin @(negedge clk); t++; end
    @(negedge clk);
    req_valid = 1'b0;
    t = 0;
    while (!res_done && t < 300) begin @(negedge clk); t++; end
    got = res_done; acc = res_accept; idx = res_index;
  endtask

  task automatic set_bnd(input int v0, input int v1, input int v2,
                         input int v3, input int v4, input int v5);
    b[0] = v0; b[1] = v1; b[2] = v2; b[3] = v3; b[4] = v4; b[5] = v5;
    for (int i = 0; i < 6; i++) cfg_wr(i + 1, b[i]);
  endtask

  function automatic logic [15:0] std_e(input logic [1:0] c, input logic d, input logic [10:0] id);
    return {c, d, 2'b00, id};
  endfunction

  function automatic logic [28:0] ext_pool(input int k);
    return 29'(k * 1000003 + 17);
  endfunction

  function automatic logic [10:0] std_pool(input int k);
    return 11'(k * 37 + 5);
  endfunction

  // expected {accept, index} from the table model
  function automatic logic [10:0] expect_lookup(input logic ext, input logic [1:0] ctrl,
                                                input logic [28:0] id);
    int lo, hi;
    logic [15:0] e;
    lo = ext ? b[3] : b[0];
    hi = ext ? b[5] : b[3];
    for (int w = lo; w < hi; w++) begin
      if (!ext) begin
        for (int h = 0; h < 2; h++) begin
          e = (h == 1) ? mdl[w][31:16] : mdl[w][15:0];
          if (!e[13] && e[15:14] == ctrl && e[10:0] == id[10:0])
            return {1'b1, 10'(w * 2 + h)};
        end
      end else if (!mdl[w][29] && mdl[w][31:30] == ctrl && mdl[w][28:0] == id) begin
        return {1'b1, 10'(w)};
      end
    end
    return 11'd0;
  endfunction

  task automatic random_round(input int n);
    int p [6];
    int tmp;
    logic got, acc, ext;
    logic [9:0] idx;
    logic [10:0] ex;
    logic [1:0] c;
    logic [28:0] id;
    cfg_wr(0, 1);
    for (int i = 0; i < 6; i++) p[i] = $urandom_range(0, 64);
    for (int i = 0; i < 6; i++)
      for (int j = 0; j < 5 - i; j++)
        if (p[j] > p[j+1]) begin tmp = p[j]; p[j] = p[j+1]; p[j+1] = tmp; end
    set_bnd(p[0], p[1], p[2], p[3], p[4], p[5]);
    for (int w = 0; w < 64; w++) begin
      if (w < b[3])
        mdl[w] = {std_e(2'($urandom_range(0, 3)), ($urandom_range(0, 3) == 0), std_pool($urandom_range(0, 5))),
                  std_e(2'($urandom_range(0, 3)), ($urandom_range(0, 3) == 0), std_pool($urandom_range(0, 5)))};
      else
        mdl[w] = {2'($urandom_range(0, 3)), 1'($urandom_range(0, 3) == 0), ext_pool($urandom_range(0, 5))};
      ram_wr(w, mdl[w]);
    end
    cfg_wr(0, 0);
    for (int k = 0; k < n; k++) begin
      ext = 1'($urandom_range(0, 1));
      c = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 3) != 0)
        id = ext ? ext_pool($urandom_range(0, 5)) : 29'(std_pool($urandom_range(0, 5)));
      else
        id = 29'($urandom);
      ex = expect_lookup(ext, c, id);
      lookup(ext, c, id, got, acc, idx);
      chk("R3 random done", 32'(got), 32'd1);
      chk(ex[10] ? "R3 random accept" : "R4 random reject", 32'(acc), 32'(ex[10]));
      if (ex[10]) chk("R3 R5 random index", 32'(idx), 32'(ex[9:0]));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!summary_done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic er, sw, got, acc, got2, acc2;
    logic [9:0] idx, idx2;
    void'($urandom(32'd2718));
    repeat (5) @(negedge clk);
    rst = 1'b0;

    // R12 reset state
    chk("R12 done low", 32'(res_done), 32'd0);
    cfg_rd(0, v); chk("R12 mode off", v, 32'd1);
    cfg_rd(4, v); chk("R12 bound zero", v, 32'd0);

    // R6 halted access
    ram_wr(10, 32'hCAFE_1234);
    ram_rd(10, v); chk("R6 ram readback", v, 32'hCAFE_1234);
    cfg_wr(3, 9); cfg_rd(3, v); chk("R6 bound readback", v, 32'd9);

    // R9 partial accesses refused
    cpu_op(1'b1, 1'b1, 9'd10, 2'd1, 32'h0, v, er, sw);
    chk("R9 halfword err", 32'(er), 32'd1);
    cpu_op(1'b0, 1'b1, 9'd10, 2'd0, 32'h0, v, er, sw);
    chk("R9 byte read err", 32'(er), 32'd1);
    ram_rd(10, v); chk("R9 word unchanged", v, 32'hCAFE_1234);

    // R2 off rejects, R1 bypass accepts
    lookup(1'b0, 2'd0, 29'd5, got, acc, idx);
    chk("R2 off done", 32'(got), 32'd1); chk("R2 off reject", 32'(acc), 32'd0);
    cfg_wr(0, 3);
    lookup(1'b1, 2'd1, 29'd77, got, acc, idx);
    chk("R1 bypass accept", 32'({got, acc}), 32'b11); chk("R1 bypass index", 32'(idx), 32'd0);
    cfg_wr(0, 2);
    lookup(1'b0, 2'd3, 29'd1, got, acc, idx);
    chk("R1 bypass2 accept", 32'({got, acc}), 32'b11);

    // R3 R5 directed: disabled low entry skipped, order low before high
    cfg_wr(0, 1);
    set_bnd(0, 2, 2, 2, 2, 2);
    mdl[0] = {std_e(2'd1, 1'b0, 11'h123), std_e(2'd1, 1'b1, 11'h123)};
    mdl[1] = {std_e(2'd1, 1'b0, 11'h123), std_e(2'd2, 1'b0, 11'h123)};
    ram_wr(0, mdl[0]); ram_wr(1, mdl[1]);
    cfg_wr(0, 0);
    lookup(1'b0, 2'd1, 29'h123, got, acc, idx);
    chk("R5 disabled skipped", 32'({got, acc}), 32'b11); chk("R5 index", 32'(idx), 32'd1);
    lookup(1'b0, 2'd2, 29'h123, got, acc, idx);
    chk("R3 low half of word1", 32'(idx), 32'd2);
    lookup(1'b1, 2'd1, 29'h123, got, acc, idx);
    chk("R4 empty table", 32'({got, acc}), 32'b10);
    lookup(1'b0, 2'd0, 29'h123, got, acc, idx);
    chk("R4 ctrl mismatch", 32'({got, acc}), 32'b10);

    // R7 layout locked while running, reads allowed
    cfg_wr(1, 7); cfg_rd(1, v); chk("R7 bound locked", v, 32'd0);
    cfg_rd(0, v); chk("R7 mode readable", v, 32'd0);

    // R8 running write touches only disable bits
    ram_wr(1, 32'hFFFF_FFFF);
    ram_rd(1, v); chk("R8 std merge", v, mdl[1] | 32'h2000_2000);
    mdl[1] = mdl[1] | 32'h2000_2000;
    lookup(1'b0, 2'd2, 29'h123, got, acc, idx);
    chk("R5 now disabled", 32'({got, acc}), 32'b10);

    random_round(80);
    random_round(80);

    // long miss table for R10 and R11
    cfg_wr(0, 1);
    set_bnd(0, 0, 0, 0, 32, 64);
    for (int w = 0; w < 64; w++) begin
      mdl[w] = {2'd0, 1'b0, ext_pool(w % 6)};
      ram_wr(w, mdl[w]);
    end
    cfg_wr(0, 0);
    fork
      lookup(1'b1, 2'd0, 29'h1ABC_DEF, got, acc, idx);
      begin
        repeat (6) @(negedge clk);
        cpu_op(1'b1, 1'b1, 9'd5, 2'd2, 32'h0, v, er, sw);
      end
    join
    chk("R10 wait seen", 32'(sw), 32'd1);
    chk("R10 search result", 32'({got, acc}), 32'b10);
    ram_rd(5, v); chk("R10 R8 ext merge", v, mdl[5] & ~32'h2000_0000);

    fork
      lookup(1'b1, 2'd0, 29'h1ABC_DEF, got2, acc2, idx2);
      begin
        repeat (8) @(negedge clk);
        cfg_wr(0, 1);
      end
    join
    chk("R11 aborted no done", 32'(got2), 32'd0);

    summary_done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule